// File: doc/BRIEF.md
# SD Card Command Path Engine

This block carries one SD/MMC command from a small register file onto the single-bit command line of a card. When requested, it also collects the card's reply. Software first loads a 32-bit argument. It then writes a command word that holds the command index, a set of option flags and a self-clearing start bit. The engine forms the 48-bit frame, appends a CRC7 and shifts the frame out most significant bit first. If the command word asks for it, the engine first sends a burst of initialisation clocks with the line held high. When the command word asks for a reply, the engine then listens for a short (48-bit) or long (136-bit) response. It checks the response and raises command-done together with any error flags in a write-one-to-clear status register.

The engine advances only on cycles where the external card clock enable `card_ce` is high. On those ticks it both drives and samples the line. The data lines, the card clock divider and any buffering lie outside this block.

The controller is one state machine with these states: `S_IDLE`, `S_WAITD`, `S_INIT`, `S_SEND`, `S_WAITR`, `S_RECV` and `S_DONE`.
- `S_IDLE` moves on a pending start bit:
  - to `S_WAITD` when the wait-for-data flag is set and `data_busy` is high;
  - otherwise to `S_INIT` when the initialisation flag is set;
  - otherwise to `S_SEND`.
- `S_WAITD` leaves when `data_busy` falls, to `S_INIT` or `S_SEND` as above.
- `S_INIT` goes to `S_SEND` after the last initialisation tick.
- `S_SEND` goes to `S_WAITR` when a response is expected, else to `S_DONE`. It does this on the tick after the frame's end bit.
- `S_WAITR` goes to `S_RECV` when it sees a start bit. It goes to `S_DONE` on timeout.
- `S_RECV` goes to `S_DONE` after the last response bit.
- `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, every register reads zero, `cmd_oe` is 0 and `cmd_out` is 1. The word register map is:

  | Address | Register |
  |---|---|
  | 0 | command |
  | 1 | argument |
  | 2 | response 0 |
  | 3 | response 1 |
  | 4 | response 2 |
  | 5 | response 3 |
  | 6 | status |

- R2: Writing a command word with bit 31 set launches a command. Bit 31 reads 1 until the engine accepts the command, one clock after the write, and reads 0 after that. Command-register writes are ignored while a start is pending or a command is in progress.
- R3: The frame is 48 bits sent MSB first, one bit per enabled tick:
  - start bit 0;
  - transmission bit 1;
  - the 6-bit index from command bits 5:0;
  - the 32-bit argument;
  - CRC7 (polynomial x^7+x^3+1) over the first 40 bits;
  - end bit 1.

  `cmd_oe` is high while the frame is driven.
- R4: With command bit 15 set, the engine drives exactly 80 ticks of logic 1 (with `cmd_oe` high) directly before the start bit.
- R5: With command bit 13 set and `data_busy` high, the frame is held back (`cmd_oe` stays 0) until `data_busy` falls.
- R6: With command bit 6 clear, command-done (status bit 2) is set after the frame. No other flag is set and the response registers are unchanged.
- R7: With bit 6 set and bit 7 clear, a 48-bit response is received. Its 32 bits following the start, transmission and index bits are stored in response 0.
- R8: With bits 6 and 7 set, a 136-bit response is received. The 128 bits that follow the 8 header bits are stored across the four response registers, with response 3 holding the most significant word.
- R9: With command bit 8 set, a CRC7 mismatch sets status bit 6. For a short response the CRC covers the first 40 bits; for a long response it covers the 120 bits after the header. With bit 8 clear, no CRC flag is raised.
- R10: If no start bit (0) is sampled within 64 ticks after the frame, status bits 8 and 2 are set and the response registers are unchanged.
- R11: A received end bit of 0, or a transmission bit of 1, sets status bit 1 (response error). Response registers are written for every received response, even one with errors.
- R12: Writing the status register clears exactly the bits written as 1. Writing all ones clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| card_ce | input | 1 | Card clock enable, one cycle wide per card clock |
| data_busy | input | 1 | High while a data transfer is still in progress |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Driven command line value |
| cmd_oe | output | 1 | Output enable for the command line |

## Verification
The assertions assume the following about the inputs:
- `card_ce` is a single-cycle pulse.
- `cmd_in` is stable around each enabled tick.
- The card does not begin a reply while the engine is still driving the line.

The bench generates `card_ce` as one cycle in every four. It changes `cmd_in` only on the falling edge just before an enabled tick. The card model idles the line high for three ticks after the frame before sending a start bit. This keeps every reply inside the 64-tick window, except in the case where the card deliberately stays silent.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // command word bit positions
    localparam int CMD_START_BIT   = 31;
    localparam int CMD_RESP_BIT    = 6;
    localparam int CMD_LONG_BIT    = 7;
    localparam int CMD_CRC_BIT     = 8;
    localparam int CMD_WAITPRE_BIT = 13;
    localparam int CMD_INIT_BIT    = 15;

    // status register bit positions
    localparam int IRQ_RESP_ERR = 1;
    localparam int IRQ_DONE     = 2;
    localparam int IRQ_CRC_ERR  = 6;
    localparam int IRQ_TIMEOUT  = 8;

    // register word addresses
    localparam logic [2:0] A_CMD   = 3'd0;
    localparam logic [2:0] A_ARG   = 3'd1;
    localparam logic [2:0] A_RESP0 = 3'd2;
    localparam logic [2:0] A_RESP1 = 3'd3;
    localparam logic [2:0] A_RESP2 = 3'd4;
    localparam logic [2:0] A_RESP3 = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAITD,
        S_INIT,
        S_SEND,
        S_WAITR,
        S_RECV,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic resp;
        logic long_r;
        logic chk;
        logic init;
        logic waitpre;
    } cmd_opts_t;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_of40(input logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int INIT_CLKS = 80,
    parameter int RESP_WAIT = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  cmd_opts_t    opts,
    input  logic [5:0]   idx,
    input  logic [31:0]  arg,
    input  logic         data_busy,
    input  logic         ce,
    input  logic         cmd_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    output logic         idle,
    output logic [31:0]  irq_set,
    output logic         resp_we,
    output logic         resp_long,
    output logic [127:0] resp_data
);

    localparam int CW0 = $clog2(LONG_BITS + 1);
    localparam int CW1 = $clog2(INIT_CLKS + 1);
    localparam int CW2 = $clog2(RESP_WAIT + 1);
    localparam int CW01 = (CW0 > CW1) ? CW0 : CW1;
    localparam int CW  = (CW01 > CW2) ? CW01 : CW2;

    localparam logic [CW-1:0] C_FRAME     = CW'(FRAME_BITS);
    localparam logic [CW-1:0] C_INIT_LAST = CW'(INIT_CLKS - 1);
    localparam logic [CW-1:0] C_WAIT_LAST = CW'(RESP_WAIT - 1);
    localparam logic [CW-1:0] C_SHORT_END = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] C_LONG_END  = CW'(LONG_BITS - 1);
    localparam logic [CW-1:0] C_WIN_SHORT = CW'(40);
    localparam logic [CW-1:0] C_WIN_LO    = CW'(8);
    localparam logic [CW-1:0] C_WIN_HI    = CW'(128);

    seq_state_t state, state_nx;
    cmd_opts_t  opts_q;
    logic [47:0]   tx_sr;
    logic [134:0]  rx_sr;
    logic [CW-1:0] cnt;
    logic          timed_out;
    logic [6:0]    crc_rx;
    logic [CW-1:0] bit_idx;
    logic          in_win;
    logic          crc_en;
    logic [31:0]   done_flags;
    logic          resp_err;
    logic          crc_bad;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (go) begin
                    if (opts.waitpre && data_busy) state_nx = S_WAITD;
                    else if (opts.init)            state_nx = S_INIT;
                    else                           state_nx = S_SEND;
                end
            end
            S_WAITD: begin
                if (!data_busy) state_nx = opts_q.init ? S_INIT : S_SEND;
            end
            S_INIT: begin
                if (ce && cnt == C_INIT_LAST) state_nx = S_SEND;
            end
            S_SEND: begin
                if (ce && cnt == C_FRAME) state_nx = opts_q.resp ? S_WAITR : S_DONE;
            end
            S_WAITR: begin
                if (ce && !cmd_in)                state_nx = S_RECV;
                else if (ce && cnt == C_WAIT_LAST) state_nx = S_DONE;
            end
            S_RECV: begin
                if (ce && cnt == (opts_q.long_r ? C_LONG_END : C_SHORT_END)) state_nx = S_DONE;
            end
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // response checks, evaluated in S_DONE
    always_comb begin
        resp_err   = !rx_sr[0] || (opts_q.long_r ? rx_sr[134] : rx_sr[46]);
        crc_bad    = opts_q.chk && (crc_rx != rx_sr[7:1]);
        done_flags = '0;
        done_flags[IRQ_DONE] = 1'b1;
        if (timed_out) begin
            done_flags[IRQ_TIMEOUT] = 1'b1;
        end else if (opts_q.resp) begin
            done_flags[IRQ_RESP_ERR] = resp_err;
            done_flags[IRQ_CRC_ERR]  = crc_bad;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opts_q    <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            cnt       <= '0;
            timed_out <= 1'b0;
            cmd_out   <= 1'b1;
            cmd_oe    <= 1'b0;
            irq_set   <= '0;
            resp_we   <= 1'b0;
        end else begin
            irq_set <= '0;
            resp_we <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (go) begin
                        opts_q    <= opts;
                        tx_sr     <= {2'b01, idx, arg, crc7_of40({2'b01, idx, arg}), 1'b1};
                        cnt       <= '0;
                        timed_out <= 1'b0;
                    end
                end
                S_WAITD: cnt <= '0;
                S_INIT: begin
                    if (ce) begin
                        cmd_oe  <= 1'b1;
                        cmd_out <= 1'b1;
                        cnt     <= (cnt == C_INIT_LAST) ? '0 : cnt + 1'b1;
                    end
                end
                S_SEND: begin
                    if (ce) begin
                        if (cnt == C_FRAME) begin
                            cmd_oe  <= 1'b0;
                            cmd_out <= 1'b1;
                            cnt     <= '0;
                        end else begin
                            cmd_oe  <= 1'b1;
                            cmd_out <= tx_sr[47];
                            tx_sr   <= {tx_sr[46:0], 1'b0};
                            cnt     <= cnt + 1'b1;
                        end
                    end
                end
                S_WAITR: begin
                    if (ce) begin
                        if (!cmd_in) begin
                            rx_sr <= {rx_sr[133:0], 1'b0};
                            cnt   <= CW'(1);
                        end else if (cnt == C_WAIT_LAST) begin
                            timed_out <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_RECV: begin
                    if (ce) begin
                        rx_sr <= {rx_sr[133:0], cmd_in};
                        cnt   <= cnt + 1'b1;
                    end
                end
                S_DONE: begin
                    irq_set <= done_flags;
                    resp_we <= opts_q.resp && !timed_out;
                end
                default: ;
            endcase
        end
    end

    // receive CRC window: bit index counted from the start bit
    assign bit_idx = (state == S_WAITR) ? '0 : cnt;
    assign in_win  = opts_q.long_r ? (bit_idx >= C_WIN_LO && bit_idx < C_WIN_HI)
                                   : (bit_idx < C_WIN_SHORT);
    assign crc_en  = ce && in_win && ((state == S_WAITR && !cmd_in) || state == S_RECV);

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_IDLE && go),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (crc_rx)
    );

    assign idle      = (state == S_IDLE);
    assign resp_long = opts_q.long_r;
    assign resp_data = opts_q.long_r ? rx_sr[127:0] : {96'b0, rx_sr[39:8]};

    // R3: line is driven only during the init burst or the frame
    a_r3_oe_scope: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> (state == S_INIT || state == S_SEND));

    // R5: frame held while the data path is busy
    a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAITD && data_busy) |=> (state == S_WAITD && !cmd_oe));

    // R10: response wait never exceeds its window
    a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAITR) |-> (cnt <= C_WAIT_LAST));

    // R6: command done is a single-cycle set pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[IRQ_DONE] |=> !irq_set[IRQ_DONE]);

    // R10: a timeout never writes response registers or flags CRC
    a_r10_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[IRQ_TIMEOUT] |-> (!resp_we && !irq_set[IRQ_CRC_ERR] && irq_set[IRQ_DONE]));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int INIT_CLKS = 80,
    parameter int RESP_WAIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        card_ce,
    input  logic        data_busy,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe
);

    logic [31:0]  cmd_q;
    logic [31:0]  arg_q;
    logic [31:0]  resp_q [4];
    logic [31:0]  stat_q;
    logic         seq_idle;
    logic         accept;
    logic         busy;
    logic [31:0]  irq_set;
    logic         resp_we;
    logic         resp_long;
    logic [127:0] resp_data;
    logic [31:0]  clr_mask;
    cmd_opts_t    opts;

    assign accept   = cmd_q[CMD_START_BIT] && seq_idle;
    assign busy     = cmd_q[CMD_START_BIT] || !seq_idle;
    assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata : 32'h0;

    assign opts.resp    = cmd_q[CMD_RESP_BIT];
    assign opts.long_r  = cmd_q[CMD_LONG_BIT];
    assign opts.chk     = cmd_q[CMD_CRC_BIT];
    assign opts.init    = cmd_q[CMD_INIT_BIT];
    assign opts.waitpre = cmd_q[CMD_WAITPRE_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            arg_q  <= '0;
            stat_q <= '0;
            for (int i = 0; i < 4; i++) resp_q[i] <= '0;
        end else begin
            if (accept) cmd_q[CMD_START_BIT] <= 1'b0;
            if (reg_we && reg_addr == A_CMD && !busy) cmd_q <= reg_wdata;
            if (reg_we && reg_addr == A_ARG) arg_q <= reg_wdata;
            stat_q <= (stat_q & ~clr_mask) | irq_set;
            if (resp_we) begin
                resp_q[0] <= resp_data[31:0];
                if (resp_long) begin
                    resp_q[1] <= resp_data[63:32];
                    resp_q[2] <= resp_data[95:64];
                    resp_q[3] <= resp_data[127:96];
                end
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = cmd_q;
            A_ARG:   reg_rdata = arg_q;
            A_RESP0: reg_rdata = resp_q[0];
            A_RESP1: reg_rdata = resp_q[1];
            A_RESP2: reg_rdata = resp_q[2];
            A_RESP3: reg_rdata = resp_q[3];
            A_STAT:  reg_rdata = stat_q;
            default: reg_rdata = 32'h0;
        endcase
    end

    sdcmd_seq #(
        .INIT_CLKS (INIT_CLKS),
        .RESP_WAIT (RESP_WAIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept),
        .opts      (opts),
        .idx       (cmd_q[5:0]),
        .arg       (arg_q),
        .data_busy (data_busy),
        .ce        (card_ce),
        .cmd_in    (cmd_in),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe),
        .idle      (seq_idle),
        .irq_set   (irq_set),
        .resp_we   (resp_we),
        .resp_long (resp_long),
        .resp_data (resp_data)
    );

    // R2: a pending start is cleared once the sequencer takes it
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[CMD_START_BIT] && seq_idle) |=> !cmd_q[CMD_START_BIT]);

    // R2: command word frozen while a command is in flight
    a_r2_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !cmd_q[CMD_START_BIT]) |=> $stable(cmd_q[30:0]));

    // R12: writing all ones with no new event clears the status
    a_r12_w1c_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STAT && reg_wdata == 32'hFFFF_FFFF && irq_set == 32'h0)
        |=> (stat_q == 32'h0));

endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        data_busy = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out;
    logic        cmd_oe;
    logic [1:0]  div;
    logic        ce;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_resp [4];

    always #4 clk = ~clk;   // 125 MHz

    always_ff @(posedge clk) begin
        if (!rst_n) div <= 2'd0;
        else        div <= div + 2'd1;
    end
    assign ce = (div == 2'd3);

    sdcmd_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .card_ce   (ce),
        .data_busy (data_busy),
        .cmd_in    (cmd_in),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe)
    );

    // kind: 0 none, 1 short ok, 2 short bad crc, 3 long ok, 4 silent, 5 short bad end, 6 long bad crc
    localparam logic [83:0] VEC [0:7] = '{
        {4'd0, 32'h0000_8000, 32'h0000_0000, 16'h0004},
        {4'd1, 32'h0000_0151, 32'h1234_5678, 16'h0004},
        {4'd2, 32'h0000_0148, 32'h0000_01AA, 16'h0044},
        {4'd3, 32'h0000_01C2, 32'hCAFE_0001, 16'h0004},
        {4'd2, 32'h0000_0077, 32'h0000_0000, 16'h0004},
        {4'd4, 32'h0000_014D, 32'h0001_0000, 16'h0104},
        {4'd5, 32'h0000_0147, 32'h55AA_55AA, 16'h0006},
        {4'd6, 32'h0000_01C9, 32'h0F0F_0F0F, 16'h0044}
    };

    function automatic logic [6:0] ref_crc(input logic [135:0] d, input int hi, input int lo);
        logic [6:0] c = '0;
        logic fb;
        for (int i = hi; i >= lo; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'b0001001 : 7'b0);
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_now(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic next_tick();
        @(negedge clk);
        while (!ce) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        while (!ce) @(negedge clk);
        cmd_in = b;
    endtask

    task automatic get_frame(output int ones, output logic [47:0] fr);
        ones = 0;
        fr = '0;
        @(negedge clk);
        while (!cmd_oe) @(negedge clk);
        while (cmd_out && ones < 200) begin
            ones++;
            next_tick();
        end
        fr[47] = cmd_out;
        for (int i = 46; i >= 0; i--) begin
            next_tick();
            fr[i] = cmd_out;
        end
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = '0;
        for (int k = 0; k < 3000; k++) begin
            rd(3'd6, st);
            if (st[2]) break;
        end
    endtask

    task automatic run_vec(input logic [83:0] v);
        logic [3:0]   kind;
        logic [31:0]  cw, arg, st;
        logic [15:0]  exp_st;
        logic [47:0]  fr, exp_fr;
        logic [135:0] rsp;
        logic [119:0] body;
        logic [31:0]  pay;
        int ones, nbits;
        kind   = v[83:80];
        cw     = v[79:48];
        arg    = v[47:16];
        exp_st = v[15:0];

        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, st);
        chk("R12 status cleared by all-ones write", {32'h0, st}, 64'h0);

        wr(3'd1, arg);
        wr(3'd0, cw | 32'h8000_0000);
        get_frame(ones, fr);
        exp_fr = {2'b01, cw[5:0], arg, 7'h00, 1'b1};
        exp_fr[7:1] = ref_crc({88'h0, exp_fr}, 47, 8);
        chk("R3 transmitted frame", {16'h0, fr}, {16'h0, exp_fr});
        chk("R4 init burst length", 64'(ones), cw[15] ? 64'd80 : 64'd0);

        pay   = arg ^ 32'h5A5A_0000;
        body  = {arg, ~arg, arg ^ 32'hA5A5_A5A5, arg[23:0]};
        rsp   = '0;
        nbits = 0;
        if (kind == 4'd1 || kind == 4'd2 || kind == 4'd5) begin
            rsp[47:0] = {2'b00, cw[5:0], pay, 7'h00, 1'b1};
            rsp[7:1]  = ref_crc(rsp, 47, 8);
            if (kind == 4'd2) rsp[1] = ~rsp[1];
            if (kind == 4'd5) rsp[0] = 1'b0;
            nbits = 48;
            exp_resp[0] = pay;
        end else if (kind == 4'd3 || kind == 4'd6) begin
            rsp = {2'b00, 6'h3F, body, 7'h00, 1'b1};
            rsp[7:1] = ref_crc(rsp, 127, 8);
            if (kind == 4'd6) rsp[3] = ~rsp[3];
            nbits = 136;
            exp_resp[0] = rsp[31:0];
            exp_resp[1] = rsp[63:32];
            exp_resp[2] = rsp[95:64];
            exp_resp[3] = rsp[127:96];
        end
        if (nbits != 0) begin
            for (int i = 0; i < 3; i++) drive_bit(1'b1);
            for (int i = nbits - 1; i >= 0; i--) drive_bit(rsp[i]);
            drive_bit(1'b1);
        end

        wait_done(st);
        // R6 R9 R10 R11: status flags per response kind
        chk("R6/R9/R10/R11 status flags", {32'h0, st}, {48'h0, exp_st});
        for (int r = 0; r < 4; r++) begin
            logic [31:0] rv;
            rd(3'(2 + r), rv);
            chk("R7/R8/R10 response register", {32'h0, rv}, {32'h0, exp_resp[r]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [47:0] fr, exp_fr;
        int ones;
        bit oe_seen;
        for (int r = 0; r < 4; r++) exp_resp[r] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R1 register reset value", {32'h0, d}, 64'h0);
        end
        chk("R1 cmd_oe idle", {63'h0, cmd_oe}, 64'h0);
        chk("R1 cmd_out idle", {63'h0, cmd_out}, 64'h1);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R12: partial clear of 0x44 leaves done
        wr(3'd6, 32'h0000_0040);
        rd(3'd6, d);
        chk("R12 partial write-one-to-clear", {32'h0, d}, 64'h4);
        wr(3'd6, 32'hFFFF_FFFF);

        // R2 and R5: start handshake, busy write ignored, wait for data
        data_busy = 1'b1;
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd0, 32'h8000_2005);
        rd_now(3'd0, d);
        chk("R2 start bit pending after write", {63'h0, d[31]}, 64'h1);
        rd(3'd0, d);
        chk("R2 start bit cleared on accept", {32'h0, d}, 64'h0000_2005);
        wr(3'd0, 32'h8000_0003);
        rd(3'd0, d);
        chk("R2 command write ignored while busy", {32'h0, d}, 64'h0000_2005);
        oe_seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (cmd_oe) oe_seen = 1'b1;
        end
        chk("R5 frame held while data busy", {63'h0, oe_seen}, 64'h0);
        data_busy = 1'b0;
        get_frame(ones, fr);
        exp_fr = {2'b01, 6'd5, 32'hDEAD_BEEF, 7'h00, 1'b1};
        exp_fr[7:1] = ref_crc({88'h0, exp_fr}, 47, 8);
        chk("R5 frame sent after data idle", {16'h0, fr}, {16'h0, exp_fr});
        wait_done(d);
        chk("R6 done without response", {32'h0, d}, 64'h4);
        oe_seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (cmd_oe) oe_seen = 1'b1;
        end
        chk("R2 ignored write launched nothing", {63'h0, oe_seen}, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule